// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block holds the digital counting chain of an integer-N synthesizer. The VCO-side path is a dual-modulus prescaler with a swallow counter A and a main counter B. The prescaler is modelled as a counter of VCO edges. For the first A prescaler periods of each cycle it divides by P+1, and after that by P. The total VCO division is therefore P*B + A. On the reference side, a programmable counter divides reference edges by R. A phase-frequency detector compares the two divided pulse trains. It drives source and sink requests to an external charge pump, with a polarity that can be inverted. A 2-bit pump current code is passed through unchanged.

Everything runs on one system clock. Reference and VCO edges arrive as one-clock strobes. Settings are written through a small address/data port into shadow registers. A divider copies them into its working set only at the end of its own cycle, so a cycle never mixes old and new settings.

Top module: `swallow_synth_div`

## Requirements
- R1: After reset, the N chain divides by 16 (P=16, A=0, B=1), the reference divider divides by 1, and `cfg_err_o`, `src_o`, `sink_o` and `cp_code_o` are all zero.
- R2: `rdiv_o` pulses for one clock, one clock after every R-th asserted `ref_edge_i` (R at address 0). A value of R=0 acts as R=1.
- R3: Writes with `cfg_we_i` high store `cfg_wdata_i` by address: 1 is A (low 6 bits), 2 is B, and 3 is control. In control, bit0 selects P (0 gives 16, 1 gives 32), bits 2:1 are the pump code, and bit3 inverts polarity.
- R4: Within a cycle, the prescaler divides by P+1 for the first A prescaler periods and by P for the remaining B-A periods. With A=B, every period uses P+1.
- R5: `fdiv_o` pulses for one clock, one clock after the final VCO edge of a cycle. The spacing between pulses is P*B+A VCO edges.
- R6: Only clocks with `vco_edge_i` high advance the N chain. If VCO edges arrive every second clock, the pulse spacing doubles in clocks.
- R7: If the working B is 0 or less than A, `cfg_err_o` is high and `fdiv_o` stays low. The working set is then reloaded on every VCO edge, so a corrected write clears the error.
- R8: New A, B, P and R values take effect only at the end of the running cycle. A cycle in progress completes with its old ratio.
- R9: The detector sets up on an `rdiv` pulse and down on an `fdiv` pulse, and clears both when both are set. Up and down are never high together.
- R10: With the invert bit at 0, `src_o` carries up and `sink_o` carries down, so a divided VCO slower than the reference yields mostly source. With the bit at 1, the two outputs swap.
- R11: `cp_code_o` shows the written pump code from the clock after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_edge_i | input | 1 | One-clock strobe per reference edge |
| vco_edge_i | input | 1 | One-clock strobe per VCO edge |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | CW (10) | Register write data |
| rdiv_o | output | 1 | Divided reference pulse |
| fdiv_o | output | 1 | Divided VCO pulse |
| src_o | output | 1 | Charge-pump source request |
| sink_o | output | 1 | Charge-pump sink request |
| cp_code_o | output | 2 | Pump current code |
| cfg_err_o | output | 1 | Working N settings invalid |

## Verification
A wrong swallow count or a modulus that switches at the wrong point does not stall the output. It shifts the spacing of `fdiv_o` by one or more edges in every cycle, so the first full cycle measured after a configuration change exposes it. A load that happens at the wrong moment lengthens or shortens the single cycle that spans the write. A fault in the detector state or its polarity shows within a few reference periods, as the wrong balance between source and sink time.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  typedef enum logic [1:0] {
    ADDR_R    = 2'd0,
    ADDR_A    = 2'd1,
    ADDR_B    = 2'd2,
    ADDR_CTRL = 2'd3
  } cfg_addr_e;

  localparam int CTRL_P32 = 0;
  localparam int CTRL_CP0 = 1;
  localparam int CTRL_INV = 3;
endpackage

// File: rtl/ref_div.sv
module ref_div #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_edge_i,
  input  logic [CW-1:0] nxt_r_i,
  output logic          rdiv_o
);
  logic [CW-1:0] act_r_q, cnt_q;
  logic          last;

  // R=0 behaves as R=1
  assign last = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, act_r_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_r_q <= CW'(1);
      cnt_q   <= '0;
      rdiv_o  <= 1'b0;
    end else begin
      rdiv_o <= ref_edge_i && last;
      if (ref_edge_i) begin
        if (last) begin
          cnt_q   <= '0;
          act_r_q <= nxt_r_i;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R2
  rdiv_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdiv_o |-> $past(ref_edge_i));
  // R8
  r_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_r_q) |-> rdiv_o);
endmodule

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int CW     = 10,
  parameter int AW     = 6,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vco_edge_i,
  input  logic [AW-1:0] nxt_a_i,
  input  logic [CW-1:0] nxt_b_i,
  input  logic          nxt_p32_i,
  output logic          fdiv_o,
  output logic          err_o
);
  localparam int PW = $clog2(PRE_HI + 1);

  logic [PW-1:0] pre_q, mod_m1;
  logic [AW-1:0] act_a_q, a_cnt_q;
  logic [CW-1:0] act_b_q, b_cnt_q;
  logic          act_p32_q;
  logic          swallow, pre_wrap, cyc_end;

  assign err_o    = (act_b_q == '0) || (act_b_q < CW'(act_a_q));
  assign swallow  = a_cnt_q < act_a_q;
  assign mod_m1   = (act_p32_q ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1)) + PW'(swallow);
  assign pre_wrap = vco_edge_i && (pre_q == mod_m1);
  assign cyc_end  = pre_wrap && (b_cnt_q == act_b_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_a_q   <= '0;
      act_b_q   <= CW'(1);
      act_p32_q <= 1'b0;
      pre_q     <= '0;
      a_cnt_q   <= '0;
      b_cnt_q   <= '0;
      fdiv_o    <= 1'b0;
    end else if (err_o) begin
      // hold, retry working set on each VCO edge
      fdiv_o  <= 1'b0;
      pre_q   <= '0;
      a_cnt_q <= '0;
      b_cnt_q <= '0;
      if (vco_edge_i) begin
        act_a_q   <= nxt_a_i;
        act_b_q   <= nxt_b_i;
        act_p32_q <= nxt_p32_i;
      end
    end else begin
      fdiv_o <= cyc_end;
      if (vco_edge_i) begin
        if (!pre_wrap) begin
          pre_q <= pre_q + PW'(1);
        end else begin
          pre_q <= '0;
          if (cyc_end) begin
            a_cnt_q   <= '0;
            b_cnt_q   <= '0;
            act_a_q   <= nxt_a_i;
            act_b_q   <= nxt_b_i;
            act_p32_q <= nxt_p32_i;
          end else begin
            b_cnt_q <= b_cnt_q + CW'(1);
            if (swallow) a_cnt_q <= a_cnt_q + AW'(1);
          end
        end
      end
    end
  end

  // R4
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PW'(PRE_HI));
  // R4
  a_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_cnt_q <= act_a_q);
  // R5
  fdiv_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdiv_o |-> $past(vco_edge_i));
  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !fdiv_o);
  // R8
  n_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_b_q) |-> (fdiv_o || $past(err_o)));
endmodule

// File: rtl/pfd.sv
module pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_p_i,
  input  logic fb_p_i,
  input  logic inv_i,
  output logic src_o,
  output logic sink_o
);
  logic up_q, dn_q, up_n, dn_n;

  always_comb begin
    up_n = up_q | ref_p_i;
    dn_n = dn_q | fb_p_i;
    if (up_n && dn_n) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  assign src_o  = inv_i ? dn_q : up_q;
  assign sink_o = inv_i ? up_q : dn_q;

  // R9
  no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));
  // R9
  up_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_p_i && !fb_p_i && !dn_q) |=> up_q);
  // R10
  out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({src_o, sink_o}));
endmodule

// File: rtl/swallow_synth_div.sv
module swallow_synth_div
  import swallow_div_pkg::*;
#(
  parameter int CW     = 10,
  parameter int AW     = 6,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_edge_i,
  input  logic          vco_edge_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [CW-1:0] cfg_wdata_i,
  output logic          rdiv_o,
  output logic          fdiv_o,
  output logic          src_o,
  output logic          sink_o,
  output logic [1:0]    cp_code_o,
  output logic          cfg_err_o
);
  logic [CW-1:0] sh_r_q, sh_b_q;
  logic [AW-1:0] sh_a_q;
  logic          sh_p32_q, sh_inv_q;
  logic [1:0]    sh_cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_r_q   <= CW'(1);
      sh_a_q   <= '0;
      sh_b_q   <= CW'(1);
      sh_p32_q <= 1'b0;
      sh_inv_q <= 1'b0;
      sh_cp_q  <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_e'(cfg_addr_i))
        ADDR_R:    sh_r_q <= cfg_wdata_i;
        ADDR_A:    sh_a_q <= cfg_wdata_i[AW-1:0];
        ADDR_B:    sh_b_q <= cfg_wdata_i;
        ADDR_CTRL: begin
          sh_p32_q <= cfg_wdata_i[CTRL_P32];
          sh_cp_q  <= cfg_wdata_i[CTRL_CP0 +: 2];
          sh_inv_q <= cfg_wdata_i[CTRL_INV];
        end
        default: ;
      endcase
    end
  end

  assign cp_code_o = sh_cp_q;

  ref_div #(.CW(CW)) i_ref_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_edge_i (ref_edge_i),
    .nxt_r_i    (sh_r_q),
    .rdiv_o     (rdiv_o)
  );

  swallow_div #(.CW(CW), .AW(AW), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) i_swallow_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vco_edge_i (vco_edge_i),
    .nxt_a_i    (sh_a_q),
    .nxt_b_i    (sh_b_q),
    .nxt_p32_i  (sh_p32_q),
    .fdiv_o     (fdiv_o),
    .err_o      (cfg_err_o)
  );

  pfd i_pfd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_p_i (rdiv_o),
    .fb_p_i  (fdiv_o),
    .inv_i   (sh_inv_q),
    .src_o   (src_o),
    .sink_o  (sink_o)
  );

  // R11
  cp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 2'd3) |=> (cp_code_o == $past(cfg_wdata_i[2:1])));
endmodule

// File: tb/test_swallow_synth_div.sv
module test_swallow_synth_div;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_edge = 1'b0, vco_edge = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          rdiv, fdiv, src, sink, cfg_err;
  logic [1:0]    cp_code;

  int total = 0, bad = 0;
  int vco_every = 1, ref_every = 1, ph = 0;

  always #4 clk = ~clk;

  swallow_synth_div i_swallow_synth_div (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_edge), .vco_edge_i(vco_edge),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rdiv_o(rdiv), .fdiv_o(fdiv), .src_o(src), .sink_o(sink),
    .cp_code_o(cp_code), .cfg_err_o(cfg_err)
  );

  always @(negedge clk) begin
    ph <= ph + 1;
    vco_edge <= ((ph + 1) % vco_every) == 0;
    ref_edge <= ((ph + 1) % ref_every) == 0;
  end

  // {p32, A, B, expected ratio}
  localparam int VEC [6][4] = '{
    '{0, 0, 1, 16}, '{0, 3, 5, 83}, '{1, 7, 7, 231},
    '{0, 15, 20, 335}, '{1, 0, 3, 96}, '{0, 1, 1, 17}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = CW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_f;
    do @(negedge clk); while (!fdiv);
  endtask

  task automatic meas_f(output int n);
    wait_f();
    n = 0;
    do begin @(negedge clk); n++; end while (!fdiv);
  endtask

  task automatic meas_r(output int n);
    do @(negedge clk); while (!rdiv);
    n = 0;
    do begin @(negedge clk); n++; end while (!rdiv);
  endtask

  task automatic count_pd(input int cyc, output int ns, output int nk);
    ns = 0; nk = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (src) ns++;
      if (sink) nk++;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, ns, nk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 err", int'(cfg_err), 0);
    chk("R1 cp", int'(cp_code), 0);
    chk("R1 pd", int'(src | sink), 0);
    meas_f(n); meas_f(n);
    chk("R1 ratio", n, 16);

    // R3 R4 R5 table walk
    foreach (VEC[i]) begin
      wr(1, 0); wr(2, VEC[i][2]); wr(1, VEC[i][1]); wr(3, VEC[i][0]);
      meas_f(n); meas_f(n); meas_f(n);
      chk("R5 ratio", n, VEC[i][3]);
    end

    // R6 VCO edges every second clock, ratio 17 -> 34 clocks
    vco_every = 2;
    meas_f(n); meas_f(n);
    chk("R6 gapped", n, 34);
    vco_every = 1;

    // R2 reference divider
    wr(0, 7);
    meas_r(n); meas_r(n);
    chk("R2 r7", n, 7);
    ref_every = 3;
    meas_r(n); meas_r(n);
    chk("R2 r7 gapped", n, 21);
    ref_every = 1;
    wr(0, 0);
    meas_r(n); meas_r(n);
    chk("R2 r0", n, 1);

    // R11 pump code
    wr(3, 4);
    chk("R11 cp", int'(cp_code), 2);

    // R8 write mid-cycle: running cycle keeps 160
    wr(1, 0); wr(2, 10); wr(3, 0);
    meas_f(n); meas_f(n);
    wait_f();
    n = 0;
    repeat (20) begin @(negedge clk); n++; end
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = CW'(2);
    @(negedge clk); n++;
    cfg_we = 1'b0;
    while (!fdiv) begin @(negedge clk); n++; end
    chk("R8 old ratio", n, 160);
    meas_f(n);
    chk("R8 new ratio", n, 32);

    // R7 invalid B < A
    wr(2, 3); wr(1, 5);
    repeat (300) @(negedge clk);
    chk("R7 err", int'(cfg_err), 1);
    n = 0;
    repeat (300) begin @(negedge clk); if (fdiv) n++; end
    chk("R7 quiet", n, 0);
    wr(2, 8);
    meas_f(n); meas_f(n);
    chk("R7 recover", n, 133);
    chk("R7 err clear", int'(cfg_err), 0);

    // R10 R9 detector direction: ref every 50, VCO divided by 98
    wr(0, 50); wr(1, 2); wr(2, 6); wr(3, 0);
    repeat (600) @(negedge clk);
    count_pd(3000, ns, nk);
    chk("R10 slow vco src", int'(ns > nk), 1);
    wr(3, 8);
    repeat (100) @(negedge clk);
    count_pd(3000, ns, nk);
    chk("R10 inverted sink", int'(nk > ns), 1);
    wr(3, 0); wr(0, 200);
    repeat (800) @(negedge clk);
    count_pd(4000, ns, nk);
    chk("R9 fast vco sink", int'(nk > ns), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule